// File: doc/BRIEF.md
# Receive Fragment List Walker

This block places the bytes of one received frame into host buffer space described by a receive descriptor. It takes the descriptor's pointer word and control word. In single-buffer mode the pointer and a 16-bit length describe one contiguous buffer, and that buffer may start on any byte.

In fragment-list mode the pointer names a word-aligned list in memory. The block reads that list through a one-word read port. The first word holds the number of fragments. Each fragment is then described by a pair of words giving an address and a length, and the order of the two words is selected per descriptor. In this mode the 16-bit field no longer gives a length: it gives the frame offset at which copying begins. Bytes before that offset are taken from the stream and discarded.

Frame bytes arrive on a valid/ready stream whose last beat is marked. Each stored byte leaves on a byte-write port as an address and data pair. Running out of buffer space does not stall the stream. The block raises an error, accepts the rest of the frame and drops it. A header-copy descriptor treats the same condition as normal completion. One status pulse reports each descriptor when it completes.

Top module: `rx_frag_walker`

## Requirements
- R1: After reset `desc_ready` is 1 and `done`, `rd_req_valid` and `s_ready` are 0. A descriptor is taken only in a cycle where `desc_valid` and `desc_ready` are both 1. While `desc_ready` is 1, no stream byte is accepted and no read is requested.
- R2: A descriptor with any of control bits 31:19 set completes in the cycle after it is taken. It completes with `sts_bad_desc`=1, issues no read, writes nothing and accepts no stream byte.
- R3: A fragment-list descriptor (control bit 16 = 1) whose pointer has bits 1:0 not equal to 00 is rejected in the same way as in R2. Every read address issued has bits 1:0 equal to 00.
- R4: With control bit 16 = 0, frame byte i is written to pointer+i for i below the length in control bits 15:0. The pointer may have any byte alignment.
- R5: With control bit 16 = 1, the count is read from the word at the pointer. The word pair for fragment k is read at pointer+4+8k, then at pointer+8k+8. With control bit 17 = 0 the first word of the pair is the address and the second is the length. With control bit 17 = 1 the order is reversed. Only bits 15:0 of the length word are used.
- R6: With control bit 16 = 1, control bits 15:0 give an offset. That many leading frame bytes are accepted and dropped. If the frame ends within the offset, the descriptor completes with no error and no fragment pair is read.
- R7: A fragment pair is read only when the previous fragment is full and the frame has not ended. A fragment of length 0 is passed over and the next pair is read.
- R8: On a descriptor with control bit 18 = 0, if all buffer space is full while frame bytes remain, `sts_frag_err`=1 is reported. In single-buffer mode the buffer space is the one buffer. The remaining bytes are accepted up to the last beat and not written, and then the descriptor completes.
- R9: A fragment count of 0 causes `sts_frag_err`=1, and the whole frame is accepted and dropped.
- R10: On a descriptor with control bit 18 = 1, full buffer space is not an error and the remaining bytes are dropped. At completion `sts_hdr_copied`=1 when `sts_frag_err` is 0.
- R11: A last byte that exactly fills the final fragment completes the descriptor without error.
- R12: While writing, `s_ready` equals `wr_ready`. Under write backpressure no byte is lost or written twice.
- R13: `done` is a one-cycle pulse. The three status flags are 0 in every cycle without `done`.
- R14: At most one read is in flight. A request that has not been accepted keeps `rd_req_valid` high and `rd_req_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor may be taken |
| desc_ptr | input | AW | Buffer or fragment-list pointer |
| desc_ctrl | input | 32 | Mode bits and length/offset field |
| rd_req_valid | output | 1 | Word read request |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Byte address of the word |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 32 | Read data |
| s_valid | input | 1 | Frame byte valid |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Last byte of frame |
| s_ready | output | 1 | Frame byte accepted |
| wr_valid | output | 1 | Byte write request |
| wr_ready | input | 1 | Byte write accepted |
| wr_addr | output | AW | Byte write address |
| wr_data | output | 8 | Byte write data |
| done | output | 1 | Descriptor complete pulse |
| sts_frag_err | output | 1 | Buffer space exhausted before end of frame |
| sts_hdr_copied | output | 1 | Header-copy descriptor completed |
| sts_bad_desc | output | 1 | Reserved bits set or list pointer misaligned |

## Verification
The bench targets four kinds of corner case.

- Zero-length fragments. A design that mishandled them would write a byte to a fragment with no room or stop walking the list.
- A frame whose last byte exactly fills the last fragment. A design that got this wrong would raise a false fragment error.
- A frame that ends inside the skip offset. A design that got this wrong would read entries it never needs or hang waiting for bytes.
- Both entry word orders. A design that confused them would write to length values as if they were addresses.

The bench also exercises an empty list, a misaligned list pointer, set reserved bits and header-copy exhaustion. It applies stalls on both the write port and the read port. An error in any of these would show up as a missing, extra or duplicated write, or as a wrong status flag.

// File: rtl/rx_fw_pkg.sv
package rx_fw_pkg;
  typedef enum logic [1:0] {FM_IDLE, FM_SKIP, FM_FILL, FM_DRAIN} fill_mode_e;
  typedef enum logic [2:0] {TS_IDLE, TS_COUNT, TS_SKIP, TS_ENTRY, TS_FILL, TS_DRAIN} walk_state_e;
  localparam int unsigned CB_LIST   = 16;
  localparam int unsigned CB_LENFST = 17;
  localparam int unsigned CB_HDR    = 18;
  localparam int unsigned CB_RSV_LO = 19;
endpackage

// File: rtl/rx_fw_wordrd.sv
module rx_fw_wordrd #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          two,
  output logic          rd_done,
  output logic [31:0]   word0,
  output logic [31:0]   word1,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [31:0]   rd_rsp_data
);
  typedef enum logic [1:0] {RS_IDLE, RS_REQ, RS_WAIT} rd_state_e;
  rd_state_e     st;
  logic [AW-1:0] addr;
  logic          two_q;
  logic          sel;

  assign rd_req_valid = (st == RS_REQ);
  assign rd_req_addr  = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RS_IDLE;
      addr    <= '0;
      two_q   <= 1'b0;
      sel     <= 1'b0;
      rd_done <= 1'b0;
      word0   <= '0;
      word1   <= '0;
    end else begin
      rd_done <= 1'b0;
      case (st)
        RS_IDLE: if (start) begin
          addr  <= start_addr;
          two_q <= two;
          sel   <= 1'b0;
          st    <= RS_REQ;
        end
        RS_REQ: if (rd_req_ready) st <= RS_WAIT;
        RS_WAIT: if (rd_rsp_valid) begin
          if (!sel) word0 <= rd_rsp_data;
          else      word1 <= rd_rsp_data;
          if (two_q && !sel) begin
            sel  <= 1'b1;
            addr <= addr + AW'(4);
            st   <= RS_REQ;
          end else begin
            st      <= RS_IDLE;
            rd_done <= 1'b1;
          end
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R14
  AST_NO_REQ_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && rd_req_ready |=> !rd_req_valid); // R14
endmodule

// File: rtl/rx_fw_fill.sv
module rx_fw_fill
  import rx_fw_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  fill_mode_e    load_mode,
  input  logic [AW-1:0] load_addr,
  input  logic [LW-1:0] load_len,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          evt_eof,
  output logic          evt_exh
);
  fill_mode_e    mode;
  logic [AW-1:0] cur;
  logic [LW-1:0] rem;
  logic          beat;

  assign s_ready  = (mode == FM_FILL) ? wr_ready : ((mode == FM_SKIP) || (mode == FM_DRAIN));
  assign wr_valid = (mode == FM_FILL) && s_valid;
  assign wr_addr  = cur;
  assign wr_data  = s_data;
  assign beat     = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= FM_IDLE;
      cur     <= '0;
      rem     <= '0;
      evt_eof <= 1'b0;
      evt_exh <= 1'b0;
    end else begin
      evt_eof <= 1'b0;
      evt_exh <= 1'b0;
      if (load) begin
        cur <= load_addr;
        rem <= load_len;
        if (load_mode != FM_DRAIN && load_len == '0) begin
          mode    <= FM_IDLE;
          evt_exh <= 1'b1;
        end else begin
          mode <= load_mode;
        end
      end else if (beat) begin
        if (s_last) begin
          mode    <= FM_IDLE;
          evt_eof <= 1'b1;
        end else if (mode != FM_DRAIN) begin
          rem <= rem - LW'(1);
          cur <= cur + AW'(1);
          if (rem == LW'(1)) begin
            mode    <= FM_IDLE;
            evt_exh <= 1'b1;
          end
        end
      end
    end
  end

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(evt_eof && evt_exh)); // R11
  AST_FILL_HAS_ROOM: assert property (@(posedge clk) disable iff (rst)
    (mode == FM_FILL) |-> (rem != '0)); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    wr_valid && wr_ready && !s_last |=> (wr_valid |-> wr_addr == $past(wr_addr) + AW'(1))); // R4
endmodule

// File: rtl/rx_frag_walker.sv
module rx_frag_walker
  import rx_fw_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          desc_valid,
  output logic          desc_ready,
  input  logic [AW-1:0] desc_ptr,
  input  logic [31:0]   desc_ctrl,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [31:0]   rd_rsp_data,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done,
  output logic          sts_frag_err,
  output logic          sts_hdr_copied,
  output logic          sts_bad_desc
);
  localparam int ENTRY_SHIFT = 3;

  walk_state_e   st;
  logic [AW-1:0] base;
  logic [LW-1:0] off;
  logic [CW-1:0] cnt, idx;
  logic          lf_q, hdr_q, err_q;

  logic          rd_start, rd_two, rd_done;
  logic [AW-1:0] rd_addr;
  logic [31:0]   w0, w1;

  logic          ld;
  fill_mode_e    ld_mode;
  logic [AW-1:0] ld_addr;
  logic [LW-1:0] ld_len;
  logic          evt_eof, evt_exh;

  logic          bad_now;
  logic [AW-1:0] entry_addr;

  assign desc_ready = (st == TS_IDLE) && !done;
  assign bad_now    = (desc_ctrl[31:CB_RSV_LO] != '0) ||
                      (desc_ctrl[CB_LIST] && desc_ptr[1:0] != 2'b00);
  assign entry_addr = base + AW'(4) + (AW'(idx) << ENTRY_SHIFT);

  rx_fw_wordrd #(.AW(AW)) u_rd (
    .clk, .rst,
    .start(rd_start), .start_addr(rd_addr), .two(rd_two),
    .rd_done, .word0(w0), .word1(w1),
    .rd_req_valid, .rd_req_ready, .rd_req_addr,
    .rd_rsp_valid, .rd_rsp_data
  );

  rx_fw_fill #(.AW(AW), .LW(LW), .DW(8)) u_fill (
    .clk, .rst,
    .load(ld), .load_mode(ld_mode), .load_addr(ld_addr), .load_len(ld_len),
    .s_valid, .s_data, .s_last, .s_ready,
    .wr_valid, .wr_ready, .wr_addr, .wr_data,
    .evt_eof, .evt_exh
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= TS_IDLE;
      base           <= '0;
      off            <= '0;
      cnt            <= '0;
      idx            <= '0;
      lf_q           <= 1'b0;
      hdr_q          <= 1'b0;
      err_q          <= 1'b0;
      rd_start       <= 1'b0;
      rd_two         <= 1'b0;
      rd_addr        <= '0;
      ld             <= 1'b0;
      ld_mode        <= FM_IDLE;
      ld_addr        <= '0;
      ld_len         <= '0;
      done           <= 1'b0;
      sts_frag_err   <= 1'b0;
      sts_hdr_copied <= 1'b0;
      sts_bad_desc   <= 1'b0;
    end else begin
      done           <= 1'b0;
      sts_frag_err   <= 1'b0;
      sts_hdr_copied <= 1'b0;
      sts_bad_desc   <= 1'b0;
      rd_start       <= 1'b0;
      ld             <= 1'b0;
      case (st)
        TS_IDLE: if (desc_valid && desc_ready) begin
          base  <= desc_ptr;
          lf_q  <= desc_ctrl[CB_LENFST];
          hdr_q <= desc_ctrl[CB_HDR];
          off   <= desc_ctrl[LW-1:0];
          err_q <= 1'b0;
          idx   <= '0;
          if (bad_now) begin
            done         <= 1'b1;
            sts_bad_desc <= 1'b1;
          end else if (desc_ctrl[CB_LIST]) begin
            rd_start <= 1'b1;
            rd_addr  <= desc_ptr;
            rd_two   <= 1'b0;
            st       <= TS_COUNT;
          end else begin
            ld      <= 1'b1;
            ld_mode <= FM_FILL;
            ld_addr <= desc_ptr;
            ld_len  <= desc_ctrl[LW-1:0];
            cnt     <= CW'(1);
            idx     <= CW'(1);
            st      <= TS_FILL;
          end
        end
        TS_COUNT: if (rd_done) begin
          cnt <= w0[CW-1:0];
          ld  <= 1'b1;
          if (w0[CW-1:0] == '0) begin
            err_q   <= 1'b1;
            ld_mode <= FM_DRAIN;
            st      <= TS_DRAIN;
          end else begin
            ld_mode <= FM_SKIP;
            ld_len  <= off;
            st      <= TS_SKIP;
          end
        end
        TS_SKIP: begin
          if (evt_eof) begin
            done           <= 1'b1;
            sts_hdr_copied <= hdr_q;
            st             <= TS_IDLE;
          end else if (evt_exh) begin
            rd_start <= 1'b1;
            rd_addr  <= entry_addr;
            rd_two   <= 1'b1;
            st       <= TS_ENTRY;
          end
        end
        TS_ENTRY: if (rd_done) begin
          ld      <= 1'b1;
          ld_mode <= FM_FILL;
          ld_addr <= lf_q ? w1 : w0;
          ld_len  <= lf_q ? w0[LW-1:0] : w1[LW-1:0];
          idx     <= idx + CW'(1);
          st      <= TS_FILL;
        end
        TS_FILL: begin
          if (evt_eof) begin
            done           <= 1'b1;
            sts_hdr_copied <= hdr_q;
            st             <= TS_IDLE;
          end else if (evt_exh) begin
            if (idx < cnt) begin
              rd_start <= 1'b1;
              rd_addr  <= entry_addr;
              rd_two   <= 1'b1;
              st       <= TS_ENTRY;
            end else begin
              if (!hdr_q) err_q <= 1'b1;
              ld      <= 1'b1;
              ld_mode <= FM_DRAIN;
              st      <= TS_DRAIN;
            end
          end
        end
        TS_DRAIN: if (evt_eof) begin
          done           <= 1'b1;
          sts_frag_err   <= err_q;
          sts_hdr_copied <= hdr_q && !err_q;
          st             <= TS_IDLE;
        end
        default: st <= TS_IDLE;
      endcase
    end
  end

  AST_LIST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> rd_req_addr[1:0] == 2'b00); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R13
  AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    (sts_frag_err || sts_hdr_copied || sts_bad_desc) |-> done); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    desc_ready |-> !s_ready && !rd_req_valid); // R1
  AST_ERR_HDR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sts_frag_err && sts_hdr_copied)); // R10
endmodule

// File: tb/rx_frag_walker_bench.sv
module rx_frag_walker_bench;
  localparam int AW = 32;
  localparam logic [31:0] FL = 32'h1 << 16;
  localparam logic [31:0] LF = 32'h1 << 17;
  localparam logic [31:0] HD = 32'h1 << 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          desc_valid = 1'b0, desc_ready;
  logic [AW-1:0] desc_ptr = '0;
  logic [31:0]   desc_ctrl = '0;
  logic          rd_req_valid, rd_req_ready = 1'b1;
  logic [AW-1:0] rd_req_addr;
  logic          rd_rsp_valid = 1'b0;
  logic [31:0]   rd_rsp_data = '0;
  logic          s_valid = 1'b0, s_last = 1'b0, s_ready;
  logic [7:0]    s_data = '0;
  logic          wr_valid, wr_ready = 1'b1;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          done, sts_frag_err, sts_hdr_copied, sts_bad_desc;

  rx_frag_walker u_rx_frag_walker (.*);

  logic [31:0] mem [0:63];
  logic [7:0]  frame_q [$];
  logic [39:0] exp_wr [$];
  logic [31:0] exp_rd [$];
  int checks = 0, fails = 0, cyc = 0;
  bit src_en = 0, bp_wr = 0, bp_rd = 0, beat_acc = 0, pend = 0, done_seen = 0;
  bit hold_pend = 0;
  logic [AW-1:0] paddr = '0, hold_addr = '0;
  logic [2:0] got_flags = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (beat_acc && frame_q.size() > 0) void'(frame_q.pop_front());
    s_valid  = src_en && frame_q.size() > 0;
    s_data   = s_valid ? frame_q[0] : 8'h00;
    s_last   = s_valid && frame_q.size() == 1;
    wr_ready = !bp_wr || (cyc % 3 != 0);
    rd_req_ready = !bp_rd || (cyc % 2 == 0);
    rd_rsp_valid = 1'b0;
    if (pend) begin
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = mem[paddr[7:2]];
      pend = 0;
    end
    #1;
    if (!rst) begin
      beat_acc = s_valid && s_ready;
      if (hold_pend) begin
        chk(rd_req_valid && rd_req_addr == hold_addr, "R14 held request", {31'd0, rd_req_valid, rd_req_addr}, {31'd0, 1'b1, hold_addr});
        hold_pend = 0;
      end
      if (rd_req_valid && !rd_req_ready) begin
        hold_pend = 1;
        hold_addr = rd_req_addr;
      end
      if (wr_valid) chk(s_ready == wr_ready, "R12 ready follows write", 64'(s_ready), 64'(wr_ready));
      if (wr_valid && wr_ready) begin
        if (exp_wr.size() == 0) chk(0, "R4 unexpected write", {24'd0, wr_addr, wr_data}, 64'd0);
        else begin
          logic [39:0] e;
          e = exp_wr.pop_front();
          chk({wr_addr, wr_data} == e, "R4 write addr/data", {24'd0, wr_addr, wr_data}, {24'd0, e});
        end
      end
      if (rd_req_valid && rd_req_ready) begin
        if (exp_rd.size() == 0) chk(0, "R5 unexpected read", 64'(rd_req_addr), 64'd0);
        else begin
          logic [31:0] e;
          e = exp_rd.pop_front();
          chk(rd_req_addr == e, "R5 read addr", 64'(rd_req_addr), 64'(e));
        end
        pend = 1;
        paddr = rd_req_addr;
      end
      if (done) begin
        done_seen = 1;
        got_flags = {sts_bad_desc, sts_hdr_copied, sts_frag_err};
      end else begin
        chk({sts_bad_desc, sts_hdr_copied, sts_frag_err} == 3'b000, "R13 flags without done",
            64'({sts_bad_desc, sts_hdr_copied, sts_frag_err}), 64'd0);
      end
    end
  end

  task automatic run(input logic [31:0] ptr, input logic [31:0] ctrl, input int n, input logic [7:0] seed, input string tag);
    bit bad, e_err, e_hdr;
    int cnt, skip, k, i, fl;
    logic [31:0] fa, a0, ww0, ww1;
    logic [7:0] fr [$];
    for (int j = 0; j < n; j++) fr.push_back(seed + 8'(j * 7));
    bad = (ctrl[31:19] != 0) || (ctrl[16] && ptr[1:0] != 2'b00);
    e_err = 0;
    if (!bad) begin
      if (!ctrl[16]) begin cnt = 1; skip = 0; end
      else begin exp_rd.push_back(ptr); cnt = int'(mem[ptr[7:2]][15:0]); skip = int'(ctrl[15:0]); end
      if (ctrl[16] && cnt == 0) e_err = 1;
      else begin
        i = skip; k = 0;
        while (i < n) begin
          if (k == cnt) begin
            if (!ctrl[18]) e_err = 1;
            break;
          end
          if (!ctrl[16]) begin fa = ptr; fl = int'(ctrl[15:0]); end
          else begin
            a0 = ptr + 32'd4 + 32'(8 * k);
            exp_rd.push_back(a0); exp_rd.push_back(a0 + 32'd4);
            ww0 = mem[a0[7:2]]; ww1 = mem[(a0 + 32'd4) >> 2];
            fa = ctrl[17] ? ww1 : ww0;
            fl = int'(ctrl[17] ? ww0[15:0] : ww1[15:0]);
          end
          for (int j = 0; j < fl && i < n; j++) begin
            exp_wr.push_back({fa + 32'(j), fr[i]});
            i++;
          end
          k++;
        end
      end
    end
    e_hdr = ctrl[18] && !e_err && !bad;
    done_seen = 0;
    @(negedge clk);
    while (!desc_ready) @(negedge clk);
    desc_ptr = ptr; desc_ctrl = ctrl; desc_valid = 1'b1;
    if (!bad) begin frame_q = fr; src_en = 1; end
    @(negedge clk);
    desc_valid = 1'b0;
    for (int t = 0; t < 3000 && !done_seen; t++) @(negedge clk);
    chk(done_seen, {tag, " completion"}, 64'(done_seen), 64'd1);
    repeat (3) @(negedge clk);
    chk(got_flags == {bad, e_hdr, e_err}, {tag, " status {bad,hdr,err}"}, 64'(got_flags), 64'({bad, e_hdr, e_err}));
    chk(exp_wr.size() == 0, {tag, " writes outstanding"}, 64'(exp_wr.size()), 64'd0);
    chk(exp_rd.size() == 0, {tag, " reads outstanding"}, 64'(exp_rd.size()), 64'd0);
    chk(frame_q.size() == 0, {tag, " frame fully taken"}, 64'(frame_q.size()), 64'd0);
    src_en = 0; exp_wr.delete(); exp_rd.delete(); frame_q.delete();
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int j = 0; j < 64; j++) mem[j] = 32'hDEAD0000 + 32'(j);
    mem[8'h40 >> 2] = 32'd3;
    mem[8'h44 >> 2] = 32'h0000_2000; mem[8'h48 >> 2] = 32'hABCD_0003;
    mem[8'h4C >> 2] = 32'h0000_3001; mem[8'h50 >> 2] = 32'h0000_0000;
    mem[8'h54 >> 2] = 32'h0000_4000; mem[8'h58 >> 2] = 32'h0000_0005;
    mem[8'h80 >> 2] = 32'd2;
    mem[8'h84 >> 2] = 32'h0000_0003; mem[8'h88 >> 2] = 32'h0000_5000;
    mem[8'h8C >> 2] = 32'h0000_0002; mem[8'h90 >> 2] = 32'h0000_6000;
    mem[8'hC0 >> 2] = 32'd0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(desc_ready == 1'b1, "R1 reset ready", 64'(desc_ready), 64'd1);
    chk({done, rd_req_valid, s_ready} == 3'b000, "R1 reset quiet", 64'({done, rd_req_valid, s_ready}), 64'd0);
    run(32'h0000_1003, 32'd10, 6, 8'h11, "R4 single unaligned");
    bp_wr = 1;
    run(32'h0000_1100, 32'd4, 9, 8'h21, "R8 R12 single overflow");
    run(32'h0000_1000, 32'h0008_0004, 5, 8'h31, "R2 reserved bit");
    run(32'h0000_0042, FL, 5, 8'h41, "R3 misaligned list");
    bp_rd = 1;
    run(32'h0000_0040, FL | 32'd2, 9, 8'h51, "R5 R6 R7 list ptr-first");
    run(32'h0000_0080, FL | LF, 5, 8'h61, "R5 R11 list len-first exact");
    bp_wr = 0;
    run(32'h0000_00C0, FL, 7, 8'h71, "R9 empty list");
    run(32'h0000_0080, FL | LF, 9, 8'h81, "R8 list exhausted");
    run(32'h0000_0080, FL | LF | HD, 9, 8'h91, "R10 header list");
    run(32'h0000_0040, FL | 32'd20, 5, 8'hA1, "R6 frame inside offset");
    bp_rd = 0;
    run(32'h0000_2002, HD | 32'd8, 3, 8'hB1, "R10 header single fits");
    run(32'h0000_0040, FL | 32'd0, 3, 8'hC1, "R7 list first fragment only");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule